// File: doc/BRIEF.md
# Timed Four-Phase Ring Sequencer

The block is a free-running controller that cycles through four phases in a fixed ring. Each phase stays active for a programmed number of clock cycles, and then control passes to the next phase. A single down-counter times every phase. When a phase ends, the counter is reloaded with the duration of the phase that follows.

Each duration is stored in the counter as its value minus one. The counter counts down through zero to minus one. The counter is one bit wider than the largest duration needs, so when it goes from zero to minus one the borrow sets its top bit. That top bit is the expiry flag. The full register is never compared with zero, so the only decode on the critical path is a single bit.

The outputs are the encoded current phase and a pulse that is high for one cycle in the first cycle of each new phase. A surrounding design uses them to sequence periodic activity.

Top module: `dwellRing`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, that edge sets `stateCode` to 0 and `stepPulse` to 0. Reset is synchronous and active-high.
- R2: `stateCode` only moves in the order 0 → 1 → 2 → 3 → 0. Each change advances the code by exactly one, modulo 4.
- R3: A phase whose timing value is L stays active for L+1 consecutive cycles. With the default parameters the timing values are 1000 for code 0, 555 for code 1, 666 for code 2 and 784 for code 3.
- R4: `stepPulse` is 1 in exactly the first cycle of every new phase and lasts only that one cycle.
- R5: `stepPulse` is 0 in every cycle in which `stateCode` is the same as in the previous cycle.
- R6: A reset applied in the middle of any phase restarts phase 0, and that phase 0 then lasts its full value+1 cycles.
- R7: The counter register is one bit wider than the largest timing value needs (11 bits for 1000). A phase ends when the counter's top bit becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stateCode | output | 2 | Current phase, 0 to 3 |
| stepPulse | output | 1 | High for one cycle at the start of each new phase |

## Verification
The properties assume that every timing parameter is at least 1. They also assume that reset is held for at least one clock edge before it is released, so that the phase, the pulse and the dwell counter in the checker all begin from known values. The bench only drives `rst`. It raises and releases `rst` at falling edges and holds it for at least two edges each time, including the restart in the middle of a phase. The default timing values satisfy the non-zero assumption.

// File: rtl/dwellRingPkg.sv
package dwellRingPkg;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2,
    PH_D = 2'd3
  } phase_t;

  typedef struct packed {
    logic   reload;
    phase_t target;
  } ctrlStrobe_t;

  function automatic phase_t ringNext(input phase_t cur);
    case (cur)
      PH_A:    return PH_B;
      PH_B:    return PH_C;
      PH_C:    return PH_D;
      default: return PH_A;
    endcase
  endfunction

endpackage

// File: rtl/dwellRingData.sv
module dwellRingData
  import dwellRingPkg::*;
#(
  parameter int TIME_A = 1000,
  parameter int TIME_B = 555,
  parameter int TIME_C = 666,
  parameter int TIME_D = 784,
  parameter int CW     = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobe,
  output logic        expired
);

  localparam int NPH = 4;

  logic [CW-1:0] loadTable [NPH];
  logic [CW-1:0] count;
  logic [CW-1:0] reloadVal;

  for (genvar i = 0; i < NPH; i++) begin : g_load
    localparam int T = (i == 0) ? TIME_A : (i == 1) ? TIME_B :
                       (i == 2) ? TIME_C : TIME_D;
    assign loadTable[i] = CW'(T - 1);
  end

  assign reloadVal = loadTable[strobe.target];

  always_ff @(posedge clk) begin
    if (rst)                count <= loadTable[PH_A];
    else if (strobe.reload) count <= reloadVal;
    else                    count <= count - 1'b1;
  end

  assign expired = count[CW-1];

endmodule

// File: rtl/dwellRingCtrl.sv
module dwellRingCtrl
  import dwellRingPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        expired,
  output ctrlStrobe_t strobe,
  output phase_t      phase,
  output logic        stepPulse
);

  phase_t upcoming;

  assign upcoming      = ringNext(phase);
  assign strobe.reload = expired;
  assign strobe.target = upcoming;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_A;
      stepPulse <= 1'b0;
    end else begin
      stepPulse <= expired;
      if (expired) phase <= upcoming;
    end
  end

endmodule

// File: rtl/dwellRing.sv
module dwellRing
  import dwellRingPkg::*;
#(
  parameter int TIME_A = 1000,
  parameter int TIME_B = 555,
  parameter int TIME_C = 666,
  parameter int TIME_D = 784
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] stateCode,
  output logic       stepPulse
);

  localparam int MAX_AB = (TIME_A > TIME_B) ? TIME_A : TIME_B;
  localparam int MAX_CD = (TIME_C > TIME_D) ? TIME_C : TIME_D;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_T + 1) + 1;

  ctrlStrobe_t strobe;
  phase_t      phase;
  logic        expired;

  dwellRingCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .expired   (expired),
    .strobe    (strobe),
    .phase     (phase),
    .stepPulse (stepPulse)
  );

  dwellRingData #(
    .TIME_A (TIME_A),
    .TIME_B (TIME_B),
    .TIME_C (TIME_C),
    .TIME_D (TIME_D),
    .CW     (CW)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .expired (expired)
  );

  assign stateCode = phase;

endmodule

// File: rtl/dwellRingChecker.sv
module dwellRingChecker #(
  parameter int TIME_A = 1000,
  parameter int TIME_B = 555,
  parameter int TIME_C = 666,
  parameter int TIME_D = 784
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] stateCode,
  input logic       stepPulse,
  input logic       expired
);

  logic [1:0]  prevCode;
  logic [15:0] dwellCnt;
  logic [15:0] expectStep;

  assign prevCode = 2'(stateCode - 2'd1);

  always_comb begin
    case (prevCode)
      2'd0:    expectStep = 16'(TIME_A + 2);
      2'd1:    expectStep = 16'(TIME_B + 2);
      2'd2:    expectStep = 16'(TIME_C + 2);
      default: expectStep = 16'(TIME_D + 2);
    endcase
  end

  // Cycles since entering the current phase; entry cycle counts as 1.
  always_ff @(posedge clk) begin
    if (rst)            dwellCnt <= 16'd1;
    else if (stepPulse) dwellCnt <= 16'd2;
    else                dwellCnt <= dwellCnt + 16'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stateCode == 2'd0 && !stepPulse));

  assert_ring_order_R2: assert property (@(posedge clk) disable iff (rst)
    stepPulse |-> stateCode == 2'($past(stateCode) + 2'd1));

  assert_dwell_length_R3: assert property (@(posedge clk) disable iff (rst)
    stepPulse |-> dwellCnt == expectStep);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    stepPulse |=> !stepPulse);

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !stepPulse |-> $stable(stateCode));

  assert_sign_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    expired |=> (stepPulse && !expired));

endmodule

bind dwellRing dwellRingChecker #(
  .TIME_A (TIME_A),
  .TIME_B (TIME_B),
  .TIME_C (TIME_C),
  .TIME_D (TIME_D)
) u_check (
  .clk       (clk),
  .rst       (rst),
  .stateCode (stateCode),
  .stepPulse (stepPulse),
  .expired   (expired)
);

// File: tb/sim_dwellRing.sv
`timescale 1ns/1ps
module sim_dwellRing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] stateCode;
  logic       stepPulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dwellRing u0 (
    .clk       (clk),
    .rst       (rst),
    .stateCode (stateCode),
    .stepPulse (stepPulse)
  );

  function automatic int dwellOf(input int code);
    case (code)
      0:       return 1000 + 1;
      1:       return 555 + 1;
      2:       return 666 + 1;
      default: return 784 + 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs from the first cycle of phase 0 for nTransitions phase changes.
  task automatic runRing(input int nTransitions, input string tagDwell);
    int cnt = 1;
    int prev = int'(stateCode);
    int seen = 0;
    while (seen < nTransitions) begin
      @(negedge clk);
      if (int'(stateCode) != prev) begin
        check(cnt == dwellOf(prev), tagDwell, cnt, dwellOf(prev));
        check(int'(stateCode) == ((prev + 1) % 4), "R2 order", int'(stateCode), (prev + 1) % 4);
        check(stepPulse == 1'b1, "R4 pulse at entry", int'(stepPulse), 1);
        prev = int'(stateCode);
        cnt  = 1;
        seen++;
      end else begin
        cnt++;
        if (stepPulse !== 1'b0) check(1'b0, "R5 pulse while holding", int'(stepPulse), 0);
      end
    end
  endtask

  initial begin : watchdog
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    // R1: synchronous reset state.
    repeat (3) @(negedge clk);
    check(stateCode == 2'd0, "R1 reset code", int'(stateCode), 0);
    check(stepPulse == 1'b0, "R1 reset pulse", int'(stepPulse), 0);
    rst = 1'b0;

    // R3/R7: three full rings, dwell per phase = value+1 via sign-bit expiry.
    runRing(12, "R3 R7 dwell");

    // R6: reset in the middle of phase 1.
    repeat (1200) @(negedge clk);
    check(stateCode == 2'd1, "R6 precondition code", int'(stateCode), 1);
    rst = 1'b1;
    @(negedge clk);
    check(stateCode == 2'd0, "R1 mid-run reset code", int'(stateCode), 0);
    check(stepPulse == 1'b0, "R1 mid-run reset pulse", int'(stepPulse), 0);
    @(negedge clk);
    check(stateCode == 2'd0, "R1 reset held", int'(stateCode), 0);
    rst = 1'b0;
    runRing(4, "R6 dwell after restart");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule